// File: doc/BRIEF.md
# Execution-Context Memory Access Guard

This block sits between a small soft-CPU's data bus and a protected firmware scratch RAM. From three level inputs, it works out which of four execution contexts the processor is running in: firmware, application, low-privilege syscall interrupt or high-privilege syscall interrupt. From that context it derives two permissions. The first says whether the protected RAM is visible. The second says whether instruction fetches from the boot ROM may execute.

Bus accesses inside the RAM window are honoured only while the RAM is visible. A denied access writes nothing and reads back zero, but it completes on the same schedule as a granted one. The same bus also decodes two trigger addresses. A write to either one produces a single-cycle interrupt request pulse, so application code can enter a syscall handler. The CPU core, the ROM itself and the interrupt return path are outside the block. The access-level inputs are expected to be high while the matching interrupt handler runs.

Top module: `ctx_mem_guard`

## Requirements
- R1: With `sys_mode` low (firmware context), `ram_en` and `rom_exec_en` are both 1, and the RAM can be written and read back.
- R2: With `sys_mode` high and neither level input set (application context), `ram_en` and `rom_exec_en` are both 0.
- R3: With `sys_mode` high, `lvl_lo` high and `lvl_hi` low (low syscall context), `rom_exec_en` is 1 and `ram_en` is 0.
- R4: With `sys_mode` high and `lvl_hi` high (high syscall context), `ram_en` and `rom_exec_en` are both 1, whatever the value of `lvl_lo`.
- R5: When `ram_en` is 0, a selected access to the RAM window leaves the RAM contents unchanged and returns zero read data.
- R6: `ready` is 1 in the cycle after every cycle with `cs` high, whatever the address, direction or permission. It is 0 after every cycle with `cs` low.
- R7: Read data appears in the `ready` cycle. It is zero for write cycles (`we` not zero) and for addresses outside the RAM window 0xD000_0000 to 0xD000_07FF.
- R8: Bit `we[i]` writes byte lane i (`wdata[8i+7:8i]`) only. Lanes whose enable bit is clear keep their old value.
- R9: The RAM holds 512 32-bit words. The word index is `addr[10:2]`, and `addr[10]` selects one of two banks. Every word is stored independently.
- R10: A selected write (`cs` high, `we` not zero) to exactly 0xE100_0000 gives a one-cycle `irq_hi` pulse in the next cycle. A selected write to exactly 0xE000_0000 gives a one-cycle `irq_lo` pulse. The data value and the current context have no effect, and reads do not trigger.
- R11: While `rst_n` is low, `ready`, `rdata`, `irq_hi` and `irq_lo` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| sys_mode | input | 1 | High once the system has left firmware mode |
| lvl_hi | input | 1 | High while the high syscall interrupt is being serviced |
| lvl_lo | input | 1 | High while the low syscall interrupt is being serviced |
| cs | input | 1 | Bus access select |
| we | input | 4 | Byte-lane write enables; zero means read |
| addr | input | 32 | Byte address |
| wdata | input | 32 | Write data |
| ram_en | output | 1 | Protected RAM visible in the current context |
| rom_exec_en | output | 1 | Boot ROM may be executed in the current context |
| rdata | output | 32 | Read data, valid while ready is high |
| ready | output | 1 | Access completion, one cycle after cs |
| irq_hi | output | 1 | High syscall interrupt request pulse |
| irq_lo | output | 1 | Low syscall interrupt request pulse |

## Verification
A wrongly decoded context shows up on `ram_en` and `rom_exec_en` in the same cycle as the level inputs change, so each context is checked directly on those pins. A write that leaks through while the RAM is hidden does not show up at once. It appears only on the next granted read of that word, so the bench writes in a denied context and then goes back to firmware context to read the word. Bank or lane aliasing shows up one cycle after a read that follows writes to words that differ only in the bank bit or in one lane.

// File: rtl/ctx_guard_pkg.sv
package ctx_guard_pkg;

   typedef enum logic [1:0] {
      CTX_FIRMWARE = 2'd0,
      CTX_APP      = 2'd1,
      CTX_SYS_LO   = 2'd2,
      CTX_SYS_HI   = 2'd3
   } exec_ctx_e;

   // Protected RAM visible in this context
   function automatic logic ctx_ram_visible(exec_ctx_e c);
      return (c == CTX_FIRMWARE) || (c == CTX_SYS_HI);
   endfunction

   // Boot ROM executable in this context
   function automatic logic ctx_rom_exec(exec_ctx_e c);
      return (c != CTX_APP);
   endfunction

endpackage

// File: rtl/ctx_decode.sv
module ctx_decode
   import ctx_guard_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      sys_mode,
   input  logic      lvl_hi,
   input  logic      lvl_lo,
   output exec_ctx_e ctx,
   output logic      ram_en,
   output logic      rom_exec_en
);

   // The high level takes priority over the low level
   always_comb begin
      if (!sys_mode)   ctx = CTX_FIRMWARE;
      else if (lvl_hi) ctx = CTX_SYS_HI;
      else if (lvl_lo) ctx = CTX_SYS_LO;
      else             ctx = CTX_APP;
   end

   assign ram_en      = ctx_ram_visible(ctx);
   assign rom_exec_en = ctx_rom_exec(ctx);

   assert_fw_full_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !sys_mode |-> (ram_en && rom_exec_en));

   assert_app_locked_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (sys_mode && !lvl_hi && !lvl_lo) |-> (!ram_en && !rom_exec_en));

   assert_lo_no_ram_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (sys_mode && !lvl_hi && lvl_lo) |-> (!ram_en && rom_exec_en));

   assert_hi_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (sys_mode && lvl_hi) |-> (ram_en && rom_exec_en));

endmodule

// File: rtl/trig_decode.sv
module trig_decode #(
   parameter int              ADDR_W   = 32,
   parameter logic [ADDR_W-1:0] HI_ADDR = 32'hE100_0000,
   parameter logic [ADDR_W-1:0] LO_ADDR = 32'hE000_0000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs,
   input  logic              wr,
   input  logic [ADDR_W-1:0] addr,
   output logic              irq_hi,
   output logic              irq_lo
);

   logic hit_hi, hit_lo;
   logic hi_q, lo_q;

   assign hit_hi = cs && wr && (addr == HI_ADDR);
   assign hit_lo = cs && wr && (addr == LO_ADDR);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hi_q <= 1'b0;
         lo_q <= 1'b0;
      end else begin
         hi_q <= hit_hi;
         lo_q <= hit_lo;
      end
   end

   assign irq_hi = hi_q;
   assign irq_lo = lo_q;

   assert_irq_hi_src_R10: assert property (@(posedge clk) disable iff (!rst_n)
      irq_hi |-> $past(cs && wr && (addr == HI_ADDR)));

   assert_irq_lo_src_R10: assert property (@(posedge clk) disable iff (!rst_n)
      irq_lo |-> $past(cs && wr && (addr == LO_ADDR)));

   assert_irq_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({irq_hi, irq_lo}));

endmodule

// File: rtl/ram_bank.sv
module ram_bank #(
   parameter int WORDS  = 256,
   parameter int DATA_W = 32,
   localparam int LANES = DATA_W / 8,
   localparam int IDX_W = $clog2(WORDS)
) (
   input  logic              clk,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [IDX_W-1:0]  idx,
   input  logic [LANES-1:0]  lane_we,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata
);

   // One byte-wide array per lane so partial writes need no read-modify-write
   for (genvar l = 0; l < LANES; l++) begin : g_lane
      logic [7:0] mem [WORDS];
      logic [7:0] lane_q;

      always_ff @(posedge clk) begin
         if (wr_en && lane_we[l]) mem[idx] <= wdata[8*l +: 8];
         if (rd_en)               lane_q   <= mem[idx];
      end

      assign rdata[8*l +: 8] = lane_q;
   end

   assert_rd_wr_exclusive_R7: assert property (@(posedge clk)
      !(wr_en && rd_en));

endmodule

// File: rtl/ctx_mem_guard.sv
module ctx_mem_guard
   import ctx_guard_pkg::*;
#(
   parameter int                ADDR_W     = 32,
   parameter int                DATA_W     = 32,
   parameter int                NUM_BANKS  = 2,
   parameter int                BANK_WORDS = 256,
   parameter logic [ADDR_W-1:0] RAM_BASE   = 32'hD000_0000,
   parameter logic [ADDR_W-1:0] TRIG_HI    = 32'hE100_0000,
   parameter logic [ADDR_W-1:0] TRIG_LO    = 32'hE000_0000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sys_mode,
   input  logic              lvl_hi,
   input  logic              lvl_lo,
   input  logic              cs,
   input  logic [3:0]        we,
   input  logic [31:0]       addr,
   input  logic [31:0]       wdata,
   output logic              ram_en,
   output logic              rom_exec_en,
   output logic [31:0]       rdata,
   output logic              ready,
   output logic              irq_hi,
   output logic              irq_lo
);

   localparam int LANES    = DATA_W / 8;
   localparam int BYTE_OFF = $clog2(LANES);
   localparam int IDX_W    = $clog2(BANK_WORDS);
   localparam int BSEL_W   = $clog2(NUM_BANKS);
   localparam int BSEL_LSB = BYTE_OFF + IDX_W;
   localparam int WIN_LSB  = BSEL_LSB + BSEL_W;

   // Elaboration-time parameter checks
   if (DATA_W != 32 || ADDR_W != 32) begin : g_bad_width
      $error("ctx_mem_guard: bus ports are fixed at 32 bits");
   end
   if (NUM_BANKS < 2 || (NUM_BANKS & (NUM_BANKS - 1)) != 0) begin : g_bad_banks
      $error("ctx_mem_guard: NUM_BANKS must be a power of two, at least 2");
   end
   if (BANK_WORDS < 2 || (BANK_WORDS & (BANK_WORDS - 1)) != 0) begin : g_bad_words
      $error("ctx_mem_guard: BANK_WORDS must be a power of two");
   end
   if (RAM_BASE[WIN_LSB-1:0] != '0) begin : g_bad_base
      $error("ctx_mem_guard: RAM_BASE must be aligned to the RAM size");
   end

   exec_ctx_e ctx;

   ctx_decode u_ctx (
      .clk         (clk),
      .rst_n       (rst_n),
      .sys_mode    (sys_mode),
      .lvl_hi      (lvl_hi),
      .lvl_lo      (lvl_lo),
      .ctx         (ctx),
      .ram_en      (ram_en),
      .rom_exec_en (rom_exec_en)
   );

   logic wr;
   assign wr = |we;

   trig_decode #(
      .ADDR_W  (ADDR_W),
      .HI_ADDR (TRIG_HI),
      .LO_ADDR (TRIG_LO)
   ) u_trig (
      .clk    (clk),
      .rst_n  (rst_n),
      .cs     (cs),
      .wr     (wr),
      .addr   (addr),
      .irq_hi (irq_hi),
      .irq_lo (irq_lo)
   );

   // RAM window and address split
   logic              ram_hit;
   logic              access_ok;
   logic [IDX_W-1:0]  word_idx;
   logic [BSEL_W-1:0] bank_sel;

   assign ram_hit   = (addr[ADDR_W-1:WIN_LSB] == RAM_BASE[ADDR_W-1:WIN_LSB]);
   assign access_ok = cs && ram_hit && ram_en;
   assign word_idx  = addr[BSEL_LSB-1:BYTE_OFF];
   assign bank_sel  = addr[WIN_LSB-1:BSEL_LSB];

   logic [DATA_W-1:0] bank_dout [NUM_BANKS];

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      logic this_bank;
      assign this_bank = (bank_sel == BSEL_W'(b));

      ram_bank #(
         .WORDS  (BANK_WORDS),
         .DATA_W (DATA_W)
      ) u_bank (
         .clk     (clk),
         .wr_en   (access_ok && wr && this_bank),
         .rd_en   (access_ok && !wr && this_bank),
         .idx     (word_idx),
         .lane_we (we),
         .wdata   (wdata),
         .rdata   (bank_dout[b])
      );
   end

   // Completion and read-data qualification
   logic              ready_q;
   logic              rd_ok_q;
   logic [BSEL_W-1:0] bsel_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ready_q <= 1'b0;
         rd_ok_q <= 1'b0;
         bsel_q  <= '0;
      end else begin
         ready_q <= cs;
         rd_ok_q <= access_ok && !wr;
         if (access_ok && !wr) bsel_q <= bank_sel;
      end
   end

   assign ready = ready_q;
   assign rdata = rd_ok_q ? bank_dout[bsel_q] : '0;

   assert_ready_after_cs_R6: assert property (@(posedge clk) disable iff (!rst_n)
      cs |=> ready);

   assert_ready_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !cs |=> !ready);

   assert_denied_read_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (cs && !ram_en) |=> (rdata == '0));

   assert_write_rdata_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (cs && wr) |=> (rdata == '0));

   assert_rdata_only_ready_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !ready |-> (rdata == '0));

endmodule

// File: tb/ctx_mem_guard_tb_top.sv
`timescale 1ns/1ps
module ctx_mem_guard_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sys_mode = 1'b0, lvl_hi = 1'b0, lvl_lo = 1'b0;
   logic        cs = 1'b0;
   logic [3:0]  we = '0;
   logic [31:0] addr = '0, wdata = '0;
   logic        ram_en, rom_exec_en, ready, irq_hi, irq_lo;
   logic [31:0] rdata;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   always #2 clk = ~clk;

   ctx_mem_guard dut_i (
      .clk (clk), .rst_n (rst_n),
      .sys_mode (sys_mode), .lvl_hi (lvl_hi), .lvl_lo (lvl_lo),
      .cs (cs), .we (we), .addr (addr), .wdata (wdata),
      .ram_en (ram_en), .rom_exec_en (rom_exec_en),
      .rdata (rdata), .ready (ready), .irq_hi (irq_hi), .irq_lo (irq_lo)
   );

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic set_ctx(logic sm, logic hi, logic lo);
      @(negedge clk);
      sys_mode = sm; lvl_hi = hi; lvl_lo = lo;
      #0.5;
   endtask

   // One bus cycle; outputs sampled at the following falling edge
   task automatic bus(logic [3:0] w, logic [31:0] a, logic [31:0] d,
                      output logic rdy, output logic [31:0] rd,
                      output logic ih, output logic il);
      @(negedge clk);
      cs = 1'b1; we = w; addr = a; wdata = d;
      @(negedge clk);
      rdy = ready; rd = rdata; ih = irq_hi; il = irq_lo;
      cs = 1'b0; we = '0; addr = '0; wdata = '0;
   endtask

   task automatic wr32(logic [3:0] w, logic [31:0] a, logic [31:0] d);
      logic r, ih, il; logic [31:0] q;
      bus(w, a, d, r, q, ih, il);
   endtask

   task automatic rd32(logic [31:0] a, output logic [31:0] q);
      logic r, ih, il;
      bus(4'h0, a, 32'h0, r, q, ih, il);
   endtask

   task automatic t_reset;
      repeat (3) @(negedge clk);
      chk("R11 ready in reset", {31'h0, ready}, 32'h0);
      chk("R11 rdata in reset", rdata, 32'h0);
      chk("R11 irq in reset", {30'h0, irq_hi, irq_lo}, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R11 ready after reset", {31'h0, ready}, 32'h0);
   endtask

   task automatic t_firmware;
      logic [31:0] q;
      set_ctx(1'b0, 1'b0, 1'b0);
      chk("R1 ram_en", {31'h0, ram_en}, 32'h1);
      chk("R1 rom_exec_en", {31'h0, rom_exec_en}, 32'h1);
      wr32(4'hF, 32'hD000_0010, 32'h5555_AAAA);
      rd32(32'hD000_0010, q);
      chk("R1 read back", q, 32'h5555_AAAA);
   endtask

   task automatic t_app;
      logic [31:0] q;
      set_ctx(1'b1, 1'b0, 1'b0);
      chk("R2 ram_en", {31'h0, ram_en}, 32'h0);
      chk("R2 rom_exec_en", {31'h0, rom_exec_en}, 32'h0);
      rd32(32'hD000_0010, q);
      chk("R5 app read zero", q, 32'h0);
      wr32(4'hF, 32'hD000_0010, 32'h1234_5678);
      set_ctx(1'b0, 1'b0, 1'b0);
      rd32(32'hD000_0010, q);
      chk("R5 app write dropped", q, 32'h5555_AAAA);
   endtask

   task automatic t_sys_lo;
      logic [31:0] q;
      set_ctx(1'b1, 1'b0, 1'b1);
      chk("R3 ram_en", {31'h0, ram_en}, 32'h0);
      chk("R3 rom_exec_en", {31'h0, rom_exec_en}, 32'h1);
      rd32(32'hD000_0010, q);
      chk("R3 read zero", q, 32'h0);
      wr32(4'hF, 32'hD000_0010, 32'hDEAD_BEEF);
      set_ctx(1'b0, 1'b0, 1'b0);
      rd32(32'hD000_0010, q);
      chk("R5 lo write dropped", q, 32'h5555_AAAA);
   endtask

   task automatic t_sys_hi;
      logic [31:0] q;
      set_ctx(1'b1, 1'b1, 1'b0);
      chk("R4 ram_en", {31'h0, ram_en}, 32'h1);
      chk("R4 rom_exec_en", {31'h0, rom_exec_en}, 32'h1);
      rd32(32'hD000_0010, q);
      chk("R4 read", q, 32'h5555_AAAA);
      wr32(4'hF, 32'hD000_0014, 32'hCAFE_F00D);
      set_ctx(1'b1, 1'b1, 1'b1);
      chk("R4 hi wins ram_en", {31'h0, ram_en}, 32'h1);
      rd32(32'hD000_0014, q);
      chk("R4 hi wins read", q, 32'hCAFE_F00D);
   endtask

   task automatic t_lanes;
      logic [31:0] q;
      set_ctx(1'b0, 1'b0, 1'b0);
      wr32(4'hF, 32'hD000_0020, 32'h1122_3344);
      wr32(4'b0101, 32'hD000_0020, 32'hAABB_CCDD);
      rd32(32'hD000_0020, q);
      chk("R8 lanes 0,2", q, 32'h11BB_33DD);
      wr32(4'b1000, 32'hD000_0020, 32'hEE00_0000);
      rd32(32'hD000_0020, q);
      chk("R8 lane 3", q, 32'hEEBB_33DD);
   endtask

   task automatic t_banks;
      logic [31:0] q;
      wr32(4'hF, 32'hD000_000C, 32'hA0A0_0003);
      wr32(4'hF, 32'hD000_040C, 32'hB1B1_0103);
      wr32(4'hF, 32'hD000_07FC, 32'hC2C2_01FF);
      wr32(4'hF, 32'hD000_0000, 32'h0000_0001);
      rd32(32'hD000_000C, q);
      chk("R9 bank0 word3", q, 32'hA0A0_0003);
      rd32(32'hD000_040C, q);
      chk("R9 bank1 word259", q, 32'hB1B1_0103);
      rd32(32'hD000_07FC, q);
      chk("R9 last word", q, 32'hC2C2_01FF);
      rd32(32'hD000_0000, q);
      chk("R9 first word", q, 32'h0000_0001);
   endtask

   task automatic t_ready_rdata;
      logic r, ih, il; logic [31:0] q;
      bus(4'hF, 32'hD000_0030, 32'h7777_7777, r, q, ih, il);
      chk("R6 ready on write", {31'h0, r}, 32'h1);
      chk("R7 rdata zero on write", q, 32'h0);
      @(negedge clk);
      chk("R6 ready idle", {31'h0, ready}, 32'h0);
      bus(4'h0, 32'hD000_0800, 32'h0, r, q, ih, il);
      chk("R6 ready outside window", {31'h0, r}, 32'h1);
      chk("R7 rdata outside window", q, 32'h0);
      set_ctx(1'b1, 1'b0, 1'b0);
      bus(4'h0, 32'hD000_0030, 32'h0, r, q, ih, il);
      chk("R6 ready when denied", {31'h0, r}, 32'h1);
   endtask

   task automatic t_triggers;
      logic r, ih, il; logic [31:0] q;
      set_ctx(1'b1, 1'b0, 1'b0);
      bus(4'hF, 32'hE100_0000, 32'h0, r, q, ih, il);
      chk("R10 irq_hi pulse", {30'h0, ih, il}, 32'h2);
      @(negedge clk);
      chk("R10 irq_hi one cycle", {30'h0, irq_hi, irq_lo}, 32'h0);
      bus(4'h1, 32'hE000_0000, 32'hFFFF_FFFF, r, q, ih, il);
      chk("R10 irq_lo pulse", {30'h0, ih, il}, 32'h1);
      bus(4'h0, 32'hE100_0000, 32'h0, r, q, ih, il);
      chk("R10 read no trigger", {30'h0, ih, il}, 32'h0);
      bus(4'hF, 32'hE100_0004, 32'h0, r, q, ih, il);
      chk("R10 near address no trigger", {30'h0, ih, il}, 32'h0);
      set_ctx(1'b0, 1'b0, 1'b0);
      bus(4'hF, 32'hE000_0000, 32'h1, r, q, ih, il);
      chk("R10 trigger in firmware", {30'h0, ih, il}, 32'h1);
   endtask

   initial begin
      t_reset();
      t_firmware();
      t_app();
      t_sys_lo();
      t_sys_hi();
      t_lanes();
      t_banks();
      t_ready_rdata();
      t_triggers();
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      #(200000 * 4);
      if (!done) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog expired actual=running expected=done");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

endmodule